// File: doc/BRIEF.md
# Line Transceiver Diagnostic Control Register

This block is the 8-bit test and diagnostic control register of a digital subscriber line transceiver. A serial control channel (its framing is outside this block) presents each received control byte together with a write strobe. The register accepts only bytes whose two low selector bits address it. The stored byte steers a loopback multiplexer between the system-side data streams and the line-side transmit and receive paths. It also forces the receiver's sync indication out of sync, holds the line output at its bias level, and exchanges the scrambler and descrambler polynomials.

The block knows whether the transceiver runs as master or as slave. It refuses a loopback direction that is not allowed in the current role: the normal data path stays in place and an error flag is raised. When the upper nibble of the stored byte is all ones, a fixed default mode takes over. A strap pin picks the 80 kbit/s or the 160 kbit/s line rate, and every diagnostic function is switched off. A read-back port always shows the last byte that was accepted.

Top module: `dsl_diag_reg`

## Requirements
- R1: After reset the stored byte is 0x00, the data path is normal, and line_bias, poly_swap, loop_err and dflt_active are all 0.
- R2: A byte is stored on a rising clock edge only when wr_en is 1, wr_data[0] is 0 and wr_data[1] is 1. Any other byte, or any byte with wr_en at 0, leaves rd_data unchanged. rd_data shows the stored byte from the cycle after the write.
- R3: The loopback code is {bit 2, bit 3} of the stored byte, with bit 2 as the MSB. Code 00 gives the normal path: sys_out = line_rx_in and line_tx_out = sys_in.
- R4: Code 01 loops system input to system output: sys_out = sys_in, while line_tx_out = sys_in continues.
- R5: Code 10, in master mode, loops line transmit into line receive: sys_out = sys_in, line_bias = 1 and line_tx_out = 0.
- R6: Code 11, in slave mode, loops system output back into system input: sys_out = line_rx_in and line_tx_out = line_rx_in.
- R7: Code 10 in slave mode and code 11 in master mode are refused. The path stays normal (sys_out = line_rx_in, line_tx_out = sys_in) and loop_err = 1.
- R8: When bit 4 is 1, sync_out is 0 whatever sync_in is. When bit 4 is 0, sync_out follows sync_in.
- R9: When bit 6 is 1, line_bias is 1 and line_tx_out is 0.
- R10: poly_swap follows bit 5 in master mode and is 0 in slave mode.
- R11: When bits 7 to 4 are all 1, dflt_active is 1 and dflt_rate_hi equals rate_strap (0 gives 80 kbit/s, 1 gives 160 kbit/s). Loopback, unsync, line disable, polynomial swap and loop_err are all inactive, and rd_data still shows the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control byte valid strobe |
| wr_data | input | 8 | Control byte from the serial control channel |
| master_mode | input | 1 | 1 = master role, 0 = slave role |
| rate_strap | input | 1 | Default-mode rate select pin |
| sys_in | input | DATA_W | System-side data toward the line |
| line_rx_in | input | DATA_W | Data recovered from the line receiver |
| sync_in | input | 1 | Receiver sync indication (1 = in sync) |
| sys_out | output | DATA_W | System-side data output |
| line_tx_out | output | DATA_W | Data to the line transmitter |
| line_bias | output | 1 | Hold line output at bias level |
| sync_out | output | 1 | Sync indication after forcing |
| poly_swap | output | 1 | Exchange scrambler/descrambler polynomials |
| loop_err | output | 1 | Refused loopback request |
| dflt_active | output | 1 | Default mode in force |
| dflt_rate_hi | output | 1 | Default-mode rate (1 = 160 kbit/s) |
| rd_data | output | 8 | Read-back of the stored byte |

## Verification
Each loopback code is driven with sys_in and line_rx_in holding different patterns (0xA5 against 0x3C, and their swaps), so every output shows which source it is routed from. Each code is also tried in both roles, which separates an accepted loopback from a refused one. Bytes with the other three selector combinations, and a valid byte with the strobe low, show that unaddressed writes leave the read-back alone. Bytes with the all-ones upper nibble, and with the strap at both levels, show that the default mode overrides set diagnostic bits, including a loopback that would otherwise be refused.

// File: rtl/dsl_diag_pkg.sv
package dsl_diag_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    LB_NONE = 2'b00,  // normal path
    LB_SYS  = 2'b01,  // system input to system output
    LB_LINE = 2'b10,  // line transmit into line receive
    LB_ECHO = 2'b11   // system output back into system input
  } lb_mode_e;

  // selector bits {bit1, bit0} that address this register
  localparam logic [1:0] SEL_CODE = 2'b10;

  function automatic logic addr_hit(input logic [1:0] sel);
    return sel == SEL_CODE;
  endfunction

  function automatic logic dflt_pattern(input logic [3:0] hi);
    return &hi;
  endfunction

  // loopback directions that the current role forbids
  function automatic logic lb_forbidden(input lb_mode_e m, input logic master);
    return (m == LB_LINE && !master) || (m == LB_ECHO && master);
  endfunction
endpackage

// File: rtl/dsl_diag_store.sv
module dsl_diag_store
  import dsl_diag_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cfg_q,
  output logic         wr_hit
);
  assign wr_hit = wr_en && addr_hit(wr_data[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_hit) cfg_q <= wr_data;
  end
endmodule

// File: rtl/dsl_diag_policy.sv
module dsl_diag_policy
  import dsl_diag_pkg::*;
(
  input  logic       [7:2] cfg,
  input  logic             master_mode,
  input  logic             rate_strap,
  output lb_mode_e         eff_lb,
  output logic             loop_err,
  output logic             unsync,
  output logic             line_off,
  output logic             swap,
  output logic             dflt_on,
  output logic             rate_hi
);
  lb_mode_e req_lb;
  logic     refused;

  assign req_lb  = lb_mode_e'({cfg[2], cfg[3]});
  assign dflt_on = dflt_pattern(cfg[7:4]);
  assign refused = lb_forbidden(req_lb, master_mode);

  always_comb begin
    eff_lb   = LB_NONE;
    loop_err = 1'b0;
    unsync   = 1'b0;
    line_off = 1'b0;
    swap     = 1'b0;
    rate_hi  = 1'b0;
    if (dflt_on) begin
      rate_hi = rate_strap;
    end else begin
      loop_err = refused;
      eff_lb   = refused ? LB_NONE : req_lb;
      unsync   = cfg[4];
      line_off = cfg[6];
      swap     = cfg[5] && master_mode;
    end
  end
endmodule

// File: rtl/dsl_diag_route.sv
module dsl_diag_route
  import dsl_diag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  lb_mode_e              eff_lb,
  input  logic                  line_off,
  input  logic                  unsync,
  input  logic     [DATA_W-1:0] sys_in,
  input  logic     [DATA_W-1:0] line_rx_in,
  input  logic                  sync_in,
  output logic     [DATA_W-1:0] sys_out,
  output logic     [DATA_W-1:0] line_tx_out,
  output logic                  line_bias,
  output logic                  sync_out
);
  logic [DATA_W-1:0] tx_src;

  assign line_bias = line_off || (eff_lb == LB_LINE);
  assign sync_out  = sync_in && !unsync;

  always_comb begin
    case (eff_lb)
      LB_SYS, LB_LINE: sys_out = sys_in;
      default:         sys_out = line_rx_in;
    endcase
    tx_src = (eff_lb == LB_ECHO) ? line_rx_in : sys_in;
  end

  // per-bit gating toward the line driver
  for (genvar i = 0; i < DATA_W; i++) begin : g_tx
    assign line_tx_out[i] = tx_src[i] && !line_bias;
  end
endmodule

// File: rtl/dsl_diag_reg.sv
module dsl_diag_reg
  import dsl_diag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              master_mode,
  input  logic              rate_strap,
  input  logic [DATA_W-1:0] sys_in,
  input  logic [DATA_W-1:0] line_rx_in,
  input  logic              sync_in,
  output logic [DATA_W-1:0] sys_out,
  output logic [DATA_W-1:0] line_tx_out,
  output logic              line_bias,
  output logic              sync_out,
  output logic              poly_swap,
  output logic              loop_err,
  output logic              dflt_active,
  output logic              dflt_rate_hi,
  output logic [7:0]        rd_data
);
  logic [REG_W-1:0] cfg_q;
  logic             wr_hit;
  lb_mode_e         eff_lb;
  logic             unsync, line_off;

  dsl_diag_store #(.W(REG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .wr_hit(wr_hit)
  );

  dsl_diag_policy u_policy (
    .cfg(cfg_q[REG_W-1:2]), .master_mode(master_mode), .rate_strap(rate_strap),
    .eff_lb(eff_lb), .loop_err(loop_err), .unsync(unsync), .line_off(line_off),
    .swap(poly_swap), .dflt_on(dflt_active), .rate_hi(dflt_rate_hi)
  );

  dsl_diag_route #(.DATA_W(DATA_W)) u_route (
    .eff_lb(eff_lb), .line_off(line_off), .unsync(unsync),
    .sys_in(sys_in), .line_rx_in(line_rx_in), .sync_in(sync_in),
    .sys_out(sys_out), .line_tx_out(line_tx_out),
    .line_bias(line_bias), .sync_out(sync_out)
  );

  assign rd_data = cfg_q;
endmodule

// File: rtl/dsl_diag_reg_chk.sv
module dsl_diag_reg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        wr_data,
  input logic              master_mode,
  input logic [DATA_W-1:0] line_rx_in,
  input logic              sync_in,
  input logic [DATA_W-1:0] sys_out,
  input logic              poly_swap,
  input logic              loop_err,
  input logic              dflt_active,
  input logic              line_bias,
  input logic              sync_out,
  input logic [7:0]        rd_data,
  input logic              wr_hit
);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(rd_data));

  // R2
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> rd_data == $past(wr_data));

  // R7
  err_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_err |-> sys_out == line_rx_in);

  // R10
  swap_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> !poly_swap);

  // R11
  dflt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_active |-> (!loop_err && !line_bias && !poly_swap && sync_out == sync_in));

  // R11
  dflt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_err |-> rd_data[7:4] != 4'hF);
endmodule

bind dsl_diag_reg dsl_diag_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dsl_diag_reg_bench.sv
module dsl_diag_reg_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          master_mode = 1'b0;
  logic          rate_strap = 1'b0;
  logic [DW-1:0] sys_in = '0;
  logic [DW-1:0] line_rx_in = '0;
  logic          sync_in = 1'b0;
  logic [DW-1:0] sys_out, line_tx_out;
  logic          line_bias, sync_out, poly_swap, loop_err, dflt_active, dflt_rate_hi;
  logic [7:0]    rd_data;

  always #10 clk = ~clk;  // 50 MHz

  dsl_diag_reg #(.DATA_W(DW)) u_dsl_diag_reg (.*);

  typedef struct packed {
    logic [DW-1:0] so;
    logic [DW-1:0] tx;
    logic          bias;
    logic          sy;
    logic          sw;
    logic          err;
    logic          dflt;
    logic          rate;
    logic [7:0]    rd;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0;
  int    n_fail = 0;
  logic [7:0] shadow = '0;
  bit    done = 0;

  // expected outputs restated from the requirements
  function automatic obs_t predict(logic [7:0] s, logic m, logic strap,
                                   logic [DW-1:0] si, logic [DW-1:0] rx, logic sy);
    obs_t  e;
    logic [1:0] code;
    logic  refuse;
    e.rd = s;
    e.so = rx; e.tx = si; e.bias = 0; e.sy = sy; e.sw = 0; e.err = 0;
    e.dflt = 0; e.rate = 0;
    if (s[7:4] == 4'b1111) begin
      e.dflt = 1; e.rate = strap;
      return e;
    end
    code   = {s[2], s[3]};
    refuse = (code == 2'b10 && !m) || (code == 2'b11 && m);
    e.err  = refuse;
    if (refuse) code = 2'b00;
    e.sy = sy & ~s[4];
    e.sw = s[5] & m;
    case (code)
      2'b01: e.so = si;
      2'b10: begin e.so = si; e.bias = 1; end
      2'b11: begin e.so = rx; e.tx = rx; end
      default: ;
    endcase
    if (s[6]) e.bias = 1;
    if (e.bias) e.tx = '0;
    return e;
  endfunction

  task automatic step(input logic we, input logic [7:0] d, input logic m,
                      input logic strap, input logic [DW-1:0] si,
                      input logic [DW-1:0] rx, input logic sy, input string tag);
    @(negedge clk); #3;
    wr_en = we; wr_data = d; master_mode = m; rate_strap = strap;
    sys_in = si; line_rx_in = rx; sync_in = sy;
    @(posedge clk);
    if (we && d[1:0] == 2'b10) shadow = d;
    #2;
    wr_en = 1'b0;
    exp_q.push_back(predict(shadow, m, strap, si, rx, sy));
    tag_q.push_back(tag);
  endtask

  // monitor: compare at falling edge, inputs stable
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        obs_t  e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{sys_out, line_tx_out, line_bias, sync_out, poly_swap,
              loop_err, dflt_active, dflt_rate_hi, rd_data};
        n_run++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R1 reset state
    step(0, 8'h00, 0, 0, 8'hA5, 8'h3C, 1, "R1 reset");
    // R3 normal path, two patterns
    step(1, 8'h02, 1, 0, 8'hA5, 8'h3C, 1, "R3 normal a");
    step(0, 8'h00, 0, 0, 8'h3C, 8'hA5, 0, "R3 normal b");
    // R2 unaddressed selector combinations and strobe low
    step(1, 8'h49, 1, 0, 8'hA5, 8'h3C, 1, "R2 sel 01");
    step(1, 8'h4B, 1, 0, 8'hA5, 8'h3C, 1, "R2 sel 11");
    step(1, 8'h48, 1, 0, 8'hA5, 8'h3C, 1, "R2 sel 00");
    step(0, 8'h4A, 1, 0, 8'hA5, 8'h3C, 1, "R2 strobe low");
    // R4 system loop
    step(1, 8'h0A, 1, 0, 8'hA5, 8'h3C, 1, "R4 sys loop master");
    step(0, 8'h00, 0, 0, 8'h3C, 8'hA5, 1, "R4 sys loop slave");
    // R5 / R7 line loop
    step(1, 8'h06, 1, 0, 8'hA5, 8'h3C, 1, "R5 line loop master");
    step(0, 8'h00, 0, 0, 8'hA5, 8'h3C, 1, "R7 line loop slave refused");
    // R6 / R7 echo loop
    step(1, 8'h0E, 0, 0, 8'hA5, 8'h3C, 1, "R6 echo slave");
    step(0, 8'h00, 1, 0, 8'hA5, 8'h3C, 1, "R7 echo master refused");
    // R8 force unsync
    step(1, 8'h12, 1, 0, 8'hA5, 8'h3C, 1, "R8 unsync set");
    step(1, 8'h02, 1, 0, 8'hA5, 8'h3C, 1, "R8 unsync clear");
    // R9 line disable
    step(1, 8'h42, 0, 0, 8'hA5, 8'h3C, 1, "R9 line off");
    step(1, 8'h4A, 1, 0, 8'h3C, 8'hA5, 1, "R9 line off with sys loop");
    // R10 polynomial swap
    step(1, 8'h22, 1, 0, 8'hA5, 8'h3C, 1, "R10 swap master");
    step(0, 8'h00, 0, 0, 8'hA5, 8'h3C, 1, "R10 swap slave");
    // R11 default modes
    step(1, 8'hF2, 0, 0, 8'hA5, 8'h3C, 1, "R11 default rate low");
    step(0, 8'h00, 0, 1, 8'hA5, 8'h3C, 1, "R11 default rate high");
    step(1, 8'hFE, 1, 1, 8'h3C, 8'hA5, 1, "R11 default overrides refused loop");
    step(1, 8'hF6, 0, 0, 8'hA5, 8'h3C, 1, "R11 default overrides line loop");
    step(1, 8'h06, 1, 0, 8'hA5, 8'h3C, 1, "R11 leave default");
    repeat (2) @(posedge clk);
    done = 1;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard left %0d items", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule